// File: doc/BRIEF.md
# NAND Flash Per-Cycle Register Port

This block gives a processor direct, cycle-by-cycle control of a raw NAND flash bus through a small set of 32-bit registers on a simple request/acknowledge bus. Software builds every flash operation itself. A write to the command register makes one command-latch cycle and a write to the address register makes one address-latch cycle. Each access to the data register makes one byte transfer: a write strobe for a write and a read strobe for a read. Control registers hold the controller enable, chip select and write-protect state. A status register shows the flash ready/busy line after it has passed through a synchroniser.

Each flash bus cycle has a setup cycle, a strobe that stays low for `STROBE_CYC` clocks, and a hold of `HOLD_CYC` clocks. When bit 31 is set on an address write, that address byte is the last of its sequence, and the hold stretches to `HOLD_LAST` clocks so the device has time to drive busy before software polls it. The bus is stalled while a cycle runs, so no two flash cycles ever overlap.

Top module: `nand_cycle_port`

## Requirements
- R1: After reset the pins are idle: nand_ce_n=1, nand_wp_n=0, nand_we_n=1, nand_re_n=1, nand_cle=0, nand_ale=0, nand_dq_oe=0, bus_ack=0. The global control register (offset 0x00) and the flash control register (offset 0xA0) both read 0.
- R2: An access to a non-cycle register is acknowledged on the first clock edge after the request, and bus_ack is seen high one cycle later. The flash control register reads back bits 25, 24 and 5:1 as written. Bit 0 always reads 0. The global register returns its enable in bit 3.
- R3: When enabled, a write to 0xB0 makes one command cycle. In that cycle nand_cle=1, nand_ale=0, nand_dq_oe=1 and nand_dq_o holds wdata[7:0]. nand_we_n is low for exactly STROBE_CYC clocks and is preceded by a setup cycle that has data already driven.
- R4: A write to 0xB4 with bit 31 clear makes one address cycle with nand_ale=1, nand_cle=0 and the byte wdata[7:0]. The request is acknowledged 2+STROBE_CYC+HOLD_CYC edges after it is raised.
- R5: A write to 0xB4 with bit 31 set is acknowledged 2+STROBE_CYC+HOLD_LAST edges after it is raised.
- R6: A write to 0xB8 makes one write-strobe cycle with nand_cle=0, nand_ale=0 and nand_dq_o set to wdata[7:0].
- R7: A read of 0xB8 makes one read-strobe cycle. nand_re_n is low for STROBE_CYC clocks and nand_dq_oe=0. bus_rdata[7:0] returns the byte on nand_dq_i at the last strobe clock, and bits 31:8 are 0.
- R8: While a flash cycle runs, bus_ack stays low and the held request is not taken again. bus_ack is a single-cycle pulse, and nand_we_n and nand_re_n are never both low.
- R9: nand_ce_n is low exactly when global bit 3 (enable) and flash control bit 25 (chip select) are both 1. nand_wp_n follows flash control bit 24 (1 = writes allowed).
- R10: When global bit 3 is 0, writes to 0xB0, 0xB4 and 0xB8 produce no strobe and are acknowledged like register accesses. A read of 0xB8 returns 0.
- R11: Status register 0xAC bit 18 shows nand_rb (1 = ready) after a two-flop synchroniser. A read accepted on the edge right after a change still returns the old value. A read made three or more cycles after the change returns the new value.
- R12: A global write with bit 0 set clears the flash control register to 0, and bit 0 reads back 0. The enable is taken from bit 3 of the same write.
- R13: A flash control write with bit 0 set leaves the register at 0 and discards the other bits of that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_req | input | 1 | Access request, held until bus_ack |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_ack | output | 1 | One-cycle completion pulse |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_wp_n | output | 1 | Write protect, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, active low |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_dq_o | output | 8 | Byte driven to flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_o |
| nand_dq_i | input | 8 | Byte from flash |
| nand_rb | input | 1 | Ready/busy from flash, asynchronous |

## Verification
The bench measures the acknowledge latency of every access. A design that fails to stall would finish early, and one that ignores the last-address marker would lose the longer hold. A pin monitor counts strobe clocks and records latch and data values. Wrong strobe widths, a swapped command/address latch, or a byte captured at the wrong clock all show up there. Further directed cases cover the disabled controller (which must produce no strobe at all), both self-clearing resets, and a status read issued right after nand_rb changes (a missing synchroniser stage would return the new value too early).

// File: rtl/nand_port_pkg.sv
package nand_port_pkg;
  localparam int OFS_W = 8;
  localparam int REG_W = 32;

  localparam logic [OFS_W-1:0] OFS_GLOB = 8'h00;
  localparam logic [OFS_W-1:0] OFS_CTRL = 8'hA0;
  localparam logic [OFS_W-1:0] OFS_STAT = 8'hAC;
  localparam logic [OFS_W-1:0] OFS_CMD  = 8'hB0;
  localparam logic [OFS_W-1:0] OFS_ADDR = 8'hB4;
  localparam logic [OFS_W-1:0] OFS_DATA = 8'hB8;

  localparam int GLB_RST   = 0;
  localparam int GLB_EN    = 3;
  localparam int CTL_RST   = 0;
  localparam int CTL_WP    = 24;
  localparam int CTL_CS    = 25;
  localparam int STAT_RB   = 18;
  localparam int ADDR_LAST = 31;

  localparam logic [REG_W-1:0] CTL_KEEP = 32'h0300_003E;

  typedef enum logic [1:0] {K_CMD, K_ADDR, K_WR, K_RD} cyc_kind_e;
  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_STROBE, PH_HOLD} cyc_phase_e;
endpackage

// File: rtl/nand_rb_sync.sv
module nand_rb_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rb_i,
  output logic rb_o
);
  logic [STAGES-1:0] sync_q, sync_d;

  always_comb sync_d = {sync_q[STAGES-2:0], rb_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rb_o = sync_q[STAGES-1];
endmodule

// File: rtl/nand_regfile.sv
module nand_regfile
  import nand_port_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en_i,
  input  logic [OFS_W-1:0] addr_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic             nand_en_o,
  output logic [REG_W-1:0] ctrl_o
);
  logic             en_q, en_d;
  logic [REG_W-1:0] ctrl_q, ctrl_d;

  always_comb begin
    en_d   = en_q;
    ctrl_d = ctrl_q;
    if (wr_en_i) begin
      if (addr_i == OFS_GLOB) begin
        en_d = wdata_i[GLB_EN];
        if (wdata_i[GLB_RST]) ctrl_d = '0;
      end else if (addr_i == OFS_CTRL) begin
        ctrl_d = wdata_i[CTL_RST] ? '0 : (wdata_i & CTL_KEEP);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      en_q   <= en_d;
      ctrl_q <= ctrl_d;
    end
  end

  assign nand_en_o = en_q;
  assign ctrl_o    = ctrl_q;

  // R12
  glob_rst_clears_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == OFS_GLOB && wdata_i[GLB_RST]) |=> (ctrl_o == '0));
endmodule

// File: rtl/nand_cycle_seq.sv
module nand_cycle_seq
  import nand_port_pkg::*;
#(
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1,
  parameter int HOLD_LAST  = 4
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  cyc_kind_e kind_i,
  input  logic [7:0] byte_i,
  input  logic      last_i,
  input  logic [7:0] dq_i,
  output logic      busy_o,
  output logic      done_o,
  output logic [7:0] rx_o,
  output logic      cle_o,
  output logic      ale_o,
  output logic      we_n_o,
  output logic      re_n_o,
  output logic [7:0] dq_o,
  output logic      dq_oe_o
);
  localparam int MAXC = (STROBE_CYC > HOLD_LAST) ?
                        ((STROBE_CYC > HOLD_CYC) ? STROBE_CYC : HOLD_CYC) :
                        ((HOLD_LAST > HOLD_CYC) ? HOLD_LAST : HOLD_CYC);
  localparam int CW = $clog2(MAXC + 1);

  cyc_phase_e phase_q, phase_d;
  logic [CW-1:0] cnt_q, cnt_d;
  cyc_kind_e kind_q;
  logic [7:0] byte_q, rx_q, rx_d;
  logic last_q, load_en, rx_en;

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    rx_d    = rx_q;
    rx_en   = 1'b0;
    load_en = 1'b0;
    done_o  = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (start_i) begin
        phase_d = PH_SETUP;
        load_en = 1'b1;
      end
      PH_SETUP: begin
        phase_d = PH_STROBE;
        cnt_d   = CW'(STROBE_CYC - 1);
      end
      PH_STROBE: if (cnt_q == '0) begin
        phase_d = PH_HOLD;
        cnt_d   = (kind_q == K_ADDR && last_q) ? CW'(HOLD_LAST - 1) : CW'(HOLD_CYC - 1);
        if (kind_q == K_RD) begin
          rx_d  = dq_i;
          rx_en = 1'b1;
        end
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      PH_HOLD: if (cnt_q == '0) begin
        phase_d = PH_IDLE;
        done_o  = 1'b1;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      kind_q  <= K_CMD;
      byte_q  <= '0;
      last_q  <= 1'b0;
      rx_q    <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      if (load_en) begin
        kind_q <= kind_i;
        byte_q <= byte_i;
        last_q <= last_i;
      end
      if (rx_en) rx_q <= rx_d;
    end
  end

  assign busy_o  = (phase_q != PH_IDLE);
  assign cle_o   = busy_o && (kind_q == K_CMD);
  assign ale_o   = busy_o && (kind_q == K_ADDR);
  assign we_n_o  = !((phase_q == PH_STROBE) && (kind_q != K_RD));
  assign re_n_o  = !((phase_q == PH_STROBE) && (kind_q == K_RD));
  assign dq_oe_o = busy_o && (kind_q != K_RD);
  assign dq_o    = byte_q;
  assign rx_o    = rx_q;

  // R3
  setup_before_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n_o) |-> $past(dq_oe_o));

  // R3
  strobe_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n_o && $past(!we_n_o)) |-> ($stable(dq_o) && $stable(cle_o) && $stable(ale_o)));

  // R8
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n_o && !re_n_o));
endmodule

// File: rtl/nand_cycle_port.sv
module nand_cycle_port
  import nand_port_pkg::*;
#(
  parameter int STROBE_CYC = 3,
  parameter int HOLD_CYC   = 1,
  parameter int HOLD_LAST  = 4,
  parameter int RB_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_req,
  input  logic        bus_wr,
  input  logic [7:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_ack,
  output logic        nand_ce_n,
  output logic        nand_wp_n,
  output logic        nand_cle,
  output logic        nand_ale,
  output logic        nand_we_n,
  output logic        nand_re_n,
  output logic [7:0]  nand_dq_o,
  output logic        nand_dq_oe,
  input  logic [7:0]  nand_dq_i,
  input  logic        nand_rb
);
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic             nand_en, seq_busy, seq_done, rb_s;
  logic [REG_W-1:0] ctrl;
  logic [7:0]       seq_rx;
  logic             accept, launch, reg_done, ack_q, ack_d;
  logic             is_cyc_wr, is_cyc_rd;
  cyc_kind_e        kind;
  logic [REG_W-1:0] rdata_q, rdata_d, reg_rd;

  assign accept    = bus_req && !seq_busy && !ack_q;
  assign is_cyc_wr = bus_wr && (bus_addr == OFS_CMD || bus_addr == OFS_ADDR || bus_addr == OFS_DATA);
  assign is_cyc_rd = !bus_wr && (bus_addr == OFS_DATA);
  assign launch    = accept && nand_en && (is_cyc_wr || is_cyc_rd);
  assign reg_done  = accept && !launch;

  always_comb begin
    if (!bus_wr)                    kind = K_RD;
    else if (bus_addr == OFS_CMD)   kind = K_CMD;
    else if (bus_addr == OFS_ADDR)  kind = K_ADDR;
    else                            kind = K_WR;
  end

  nand_regfile u_regs (
    .clk(clk), .rst_n(rst_s), .wr_en_i(accept && bus_wr),
    .addr_i(bus_addr), .wdata_i(bus_wdata),
    .nand_en_o(nand_en), .ctrl_o(ctrl)
  );

  nand_rb_sync #(.STAGES(RB_STAGES)) u_rb (
    .clk(clk), .rst_n(rst_s), .rb_i(nand_rb), .rb_o(rb_s)
  );

  nand_cycle_seq #(.STROBE_CYC(STROBE_CYC), .HOLD_CYC(HOLD_CYC), .HOLD_LAST(HOLD_LAST)) u_seq (
    .clk(clk), .rst_n(rst_s), .start_i(launch), .kind_i(kind),
    .byte_i(bus_wdata[7:0]), .last_i(bus_wdata[ADDR_LAST]), .dq_i(nand_dq_i),
    .busy_o(seq_busy), .done_o(seq_done), .rx_o(seq_rx),
    .cle_o(nand_cle), .ale_o(nand_ale), .we_n_o(nand_we_n), .re_n_o(nand_re_n),
    .dq_o(nand_dq_o), .dq_oe_o(nand_dq_oe)
  );

  always_comb begin
    reg_rd = '0;
    unique case (bus_addr)
      OFS_GLOB: reg_rd[GLB_EN]  = nand_en;
      OFS_CTRL: reg_rd          = ctrl;
      OFS_STAT: reg_rd[STAT_RB] = rb_s;
      default:  reg_rd          = '0;
    endcase
  end

  always_comb begin
    ack_d   = reg_done || seq_done;
    rdata_d = seq_done ? {24'b0, seq_rx} : reg_rd;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ack_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      ack_q <= ack_d;
      if (ack_d) rdata_q <= rdata_d;
    end
  end

  assign bus_ack   = ack_q;
  assign bus_rdata = rdata_q;
  assign nand_ce_n = !(nand_en && ctrl[CTL_CS]);
  assign nand_wp_n = ctrl[CTL_WP];

  // R8
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    bus_ack |=> !bus_ack);

  // R10
  no_strobe_disabled_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !nand_en |-> (nand_we_n && nand_re_n));
endmodule

// File: tb/nand_cycle_port_tb.sv
`timescale 1ns/1ps
module nand_cycle_port_tb;
  localparam int S  = 3;
  localparam int H  = 1;
  localparam int HL = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic bus_req, bus_wr;
  logic [7:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic bus_ack;
  logic nand_ce_n, nand_wp_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0] nand_dq_o, nand_dq_i;
  logic nand_rb;

  always #2 clk = ~clk;

  nand_cycle_port #(.STROBE_CYC(S), .HOLD_CYC(H), .HOLD_LAST(HL)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
    .nand_ce_n(nand_ce_n), .nand_wp_n(nand_wp_n), .nand_cle(nand_cle), .nand_ale(nand_ale),
    .nand_we_n(nand_we_n), .nand_re_n(nand_re_n), .nand_dq_o(nand_dq_o), .nand_dq_oe(nand_dq_oe),
    .nand_dq_i(nand_dq_i), .nand_rb(nand_rb)
  );

  int nchk = 0, nbad = 0;
  int we_cnt, re_cnt, both_low;
  logic [7:0] we_dq;
  logic we_cle, we_ale, re_oe;

  always @(negedge clk) begin
    if (!nand_we_n) begin
      we_cnt++; we_dq = nand_dq_o; we_cle = nand_cle; we_ale = nand_ale;
    end
    if (!nand_re_n) begin
      re_cnt++; re_oe = nand_dq_oe;
    end
    if (!nand_we_n && !nand_re_n) both_low++;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_lat(input int kind, input bit last);
    if (kind == 3) return 1;
    if (kind == 1 && last) return 2 + S + HL;
    return 2 + S + H;
  endfunction

  task automatic access(input logic wr, input logic [7:0] a, input logic [31:0] wd,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    we_cnt = 0; re_cnt = 0; we_cle = 0; we_ale = 0; we_dq = 0; re_oe = 0;
    bus_req = 1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
    lat = 0;
    forever begin
      @(posedge clk); lat++;
      @(negedge clk);
      if (bus_ack || lat > 200) break;
    end
    rd = bus_rdata;
    bus_req = 0;
    @(negedge clk);
    chk("R8 ack single pulse", {31'b0, bus_ack}, 32'd0);
  endtask

  initial begin
    #(4 * 150000);
    nbad++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    int lat;
    void'($urandom(32'd1234));
    rst_n = 0; bus_req = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    nand_dq_i = 8'h00; nand_rb = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1;
    repeat (3) @(negedge clk);

    // R1
    chk("R1 pins", {24'b0, nand_ce_n, nand_wp_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe, bus_ack},
        {24'b0, 8'b1011_0000});
    access(0, 8'h00, 0, rd, lat); chk("R1 glob", rd, 0);
    access(0, 8'hA0, 0, rd, lat); chk("R1 ctrl", rd, 0);
    chk("R2 reg latency", lat, 1);

    // R10 disabled
    access(1, 8'hB0, 32'h90, rd, lat);
    chk("R10 lat", lat, 1); chk("R10 no strobe", we_cnt, 0);
    nand_dq_i = 8'h5A;
    access(0, 8'hB8, 0, rd, lat);
    chk("R10 read 0", rd, 0); chk("R10 no re", re_cnt, 0);

    // R2, R9
    access(1, 8'h00, 32'h8, rd, lat);
    access(0, 8'h00, 0, rd, lat); chk("R2 glob en", rd, 32'h8);
    chk("R9 ce off no cs", nand_ce_n, 1);
    // R13
    access(1, 8'hA0, 32'h0300_003F, rd, lat);
    access(0, 8'hA0, 0, rd, lat); chk("R13 ctrl rst", rd, 0);
    access(1, 8'hA0, 32'hFFFF_FFFE, rd, lat);
    access(0, 8'hA0, 0, rd, lat); chk("R2 ctrl readback", rd, 32'h0300_003E);
    chk("R9 ce", nand_ce_n, 0); chk("R9 wp", nand_wp_n, 1);
    access(1, 8'hA0, 32'h0200_0000, rd, lat);
    chk("R9 wp low", nand_wp_n, 0); chk("R9 ce still", nand_ce_n, 0);
    access(1, 8'hA0, 32'h0300_0000, rd, lat);

    // R3
    access(1, 8'hB0, 32'hABCD_1270, rd, lat);
    chk("R3 lat", lat, exp_lat(0, 0)); chk("R3 we width", we_cnt, S);
    chk("R3 cle/ale", {30'b0, we_cle, we_ale}, 32'b10); chk("R3 dq", we_dq, 8'h70);
    // R4
    access(1, 8'hB4, 32'h0000_0133, rd, lat);
    chk("R4 lat", lat, exp_lat(1, 0)); chk("R4 ale", {30'b0, we_cle, we_ale}, 32'b01);
    chk("R4 dq", we_dq, 8'h33);
    // R5
    access(1, 8'hB4, 32'h8000_0007, rd, lat);
    chk("R5 lat", lat, exp_lat(1, 1)); chk("R5 dq", we_dq, 8'h07);
    // R6
    access(1, 8'hB8, 32'hFFFF_FFC3, rd, lat);
    chk("R6 lat", lat, exp_lat(2, 0)); chk("R6 no latch", {30'b0, we_cle, we_ale}, 0);
    chk("R6 dq", we_dq, 8'hC3);
    // R7
    nand_dq_i = 8'hE1;
    access(0, 8'hB8, 0, rd, lat);
    chk("R7 lat", lat, exp_lat(2, 0)); chk("R7 re width", re_cnt, S);
    chk("R7 data", rd, 32'h0000_00E1); chk("R7 oe off", re_oe, 0);

    // random mix: R3 R4 R5 R6 R7
    for (int i = 0; i < 40; i++) begin
      int k = $urandom % 4;
      bit last = $urandom % 2;
      logic [7:0] b = 8'($urandom);
      nand_dq_i = 8'($urandom);
      if (k == 3) begin
        logic [7:0] e = nand_dq_i;
        access(0, 8'hB8, 0, rd, lat);
        chk("R7 rand data", rd, {24'b0, e});
        chk("R7 rand lat", lat, exp_lat(2, 0));
      end else begin
        logic [7:0] a = (k == 0) ? 8'hB0 : (k == 1) ? 8'hB4 : 8'hB8;
        access(1, a, {last, 23'($urandom), b}, rd, lat);
        chk("R3/R4/R6 rand byte", we_dq, b);
        chk("R5 rand lat", lat, exp_lat(k, last));
        chk("R3 rand cle", we_cle, (k == 0));
        chk("R4 rand ale", we_ale, (k == 1));
        chk("R3 rand width", we_cnt, S);
      end
    end
    chk("R8 never both strobes", both_low, 0);

    // R11
    @(negedge clk); nand_rb = 1;
    access(0, 8'hAC, 0, rd, lat); chk("R11 old value", rd, 0);
    repeat (3) @(negedge clk);
    access(0, 8'hAC, 0, rd, lat); chk("R11 ready", rd, 32'h0004_0000);
    nand_rb = 0;
    access(0, 8'hAC, 0, rd, lat); chk("R11 old ready", rd, 32'h0004_0000);
    repeat (3) @(negedge clk);
    access(0, 8'hAC, 0, rd, lat); chk("R11 busy", rd, 0);

    // R12
    access(1, 8'hA0, 32'h0300_0000, rd, lat);
    access(1, 8'h00, 32'h9, rd, lat);
    access(0, 8'hA0, 0, rd, lat); chk("R12 ctrl cleared", rd, 0);
    access(0, 8'h00, 0, rd, lat); chk("R12 glob", rd, 32'h8);
    chk("R12 ce", nand_ce_n, 1); chk("R12 wp", nand_wp_n, 0);

    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule